// File: doc/BRIEF.md
# Dual-Mode ADC Interrupt Controller

This block produces the two host-facing interrupt pins of a touch-screen ADC sequencer. The active-low `int_n` pin serves one of two purposes, chosen by a single configuration input. In data-ready mode it falls when a conversion sequence has been written to the result registers. It rises again when the host reads the results or when the periodic timer launches the next sequence. In limit-alarm mode it falls while any enabled channel holds a sticky out-of-range status bit. Three monitored channels (auxiliary input, battery, temperature) each carry a separate "above high limit" bit and a separate "below low limit" bit, plus one enable bit per channel.

The active-low `pen_n` pin follows the touch detector. It is forced high while its disable input is set and while the converter is busy. Results arrive as a valid-qualified stream (`res_valid`, `res_ch`, `res_data`). The block has no ready output and never applies back-pressure: every beat presented with `res_valid` high is accepted on that clock edge. All other pins are plain level or single-cycle pulse controls.

Top module: `adc_irq_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `int_n` = 1, `pen_n` = 1 and `stat_q` = 0.
- R2: With `cfg_limit_mode` = 0, a one-cycle `seq_done` pulse drives `int_n` low in the cycle after the pulse, and `int_n` stays low until a clearing event occurs.
- R3: With `spi_mode` = 0, a `host_read` pulse returns `int_n` high in the cycle after the pulse.
- R4: A `timer_start` pulse returns `int_n` high in the cycle after the pulse, even if no read took place.
- R5: When `seq_done` falls in the same cycle as `host_read` or `timer_start`, the new data wins and `int_n` is low afterwards.
- R6: With `spi_mode` = 1, a `host_read` latches a read indication. Until a `rd_release` pulse clears it, that indication clears the data-ready flag on every cycle, so a later `seq_done` holds `int_n` low for exactly one cycle. After `rd_release`, a `seq_done` holds `int_n` low again.
- R7: A result beat on channel c (0 = auxiliary, 1 = battery, 2 = temperature) sets `stat_q[2c]` when `res_data` is strictly greater than that channel's high limit. It sets `stat_q[2c+1]` when `res_data` is strictly less than the low limit. Equal values set nothing, and limits are compared only on cycles where `res_valid` is 1.
- R8: Status bits are sticky. Writing 1 at a bit position of `stat_clr` clears that bit in the next cycle. A new violation in the same cycle as its clear leaves the bit set.
- R9: With `cfg_limit_mode` = 1, `int_n` is low exactly when some `stat_q` bit of a channel with its `ch_en` bit set is 1. A cleared `ch_en[c]` masks both bits of channel c but does not stop them from recording.
- R10: `pen_n` equals the inverse of `touch`, delayed by one cycle, when `pen_dis` = 0 and the converter is idle. With `pen_dis` = 1, `pen_n` stays high.
- R11: A cycle with `conv_busy` = 1 forces `pen_n` high in the following cycle, whatever `touch` is.
- R12: The data-ready flag and the status bits are kept up to date in both modes. `cfg_limit_mode` only selects which of them drives `int_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_limit_mode | input | 1 | 0 = data-ready function on `int_n`, 1 = limit-alarm function |
| pen_dis | input | 1 | 1 disables the pen output |
| spi_mode | input | 1 | 1 = host reads latch a read indication until released |
| seq_done | input | 1 | Pulse: conversion sequence written to result registers |
| timer_start | input | 1 | Pulse: periodic timer started a new sequence |
| host_read | input | 1 | Pulse: host read the result registers |
| rd_release | input | 1 | Pulse: host cleared the latched read indication |
| conv_busy | input | 1 | Converter is converting |
| touch | input | 1 | Screen touch detected |
| res_valid | input | 1 | Result beat valid (always accepted) |
| res_ch | input | CH_W | Channel of the result beat (0 aux, 1 battery, 2 temperature) |
| res_data | input | RES_W | Result value |
| lim_hi | input | NUM_CH*RES_W | High limits, channel c at bits [c*RES_W +: RES_W] |
| lim_lo | input | NUM_CH*RES_W | Low limits, same packing |
| ch_en | input | NUM_CH | Per-channel alarm enables |
| stat_clr | input | 2*NUM_CH | Write-one-to-clear strobes for `stat_q` |
| stat_q | output | 2*NUM_CH | Status: bit 2c above-high, bit 2c+1 below-low |
| int_n | output | 1 | Active-low interrupt |
| pen_n | output | 1 | Active-low pen-touch output |

## Verification
The bench builds the block with RES_W = 12 and NUM_CH = 3. This puts both ends of the 12-bit range within reach: a high limit of 4095 that no result can exceed, and a low limit of 0 that no result can fall below. With three channels, masking one channel while another stays enabled can be checked at `int_n`. The table walk covers the strict comparison on each side and each channel's bit positions. The directed tests cover the ordering of clearing and setting events on the data-ready flag and the status bits.

// File: rtl/adc_irq_pkg.sv
`timescale 1ns/1ps
package adc_irq_pkg;
  localparam int unsigned CH_AUX = 0;
  localparam int unsigned CH_BAT = 1;
  localparam int unsigned CH_TMP = 2;

  typedef enum logic {
    INT_DATA_READY  = 1'b0,
    INT_LIMIT_ALARM = 1'b1
  } int_mode_e;
endpackage

// File: rtl/irq_limit_chan.sv
`timescale 1ns/1ps
module irq_limit_chan #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RES_W-1:0] res,
  input  logic [RES_W-1:0] lim_hi,
  input  logic [RES_W-1:0] lim_lo,
  input  logic             clr_hi,
  input  logic             clr_lo,
  output logic             hi_q,
  output logic             lo_q
);
  logic above, below;

  assign above = wr_en && (res > lim_hi);
  assign below = wr_en && (res < lim_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      if (above)       hi_q <= 1'b1;
      else if (clr_hi) hi_q <= 1'b0;
      if (below)       lo_q <= 1'b1;
      else if (clr_lo) lo_q <= 1'b0;
    end
  end

  AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hi_q && !clr_hi |=> hi_q); // R8
  AST_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lo_q && !clr_lo |=> lo_q); // R8
  AST_EQ_NO_HI: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (res == lim_hi) && !hi_q |=> !hi_q); // R7
  AST_IDLE_NO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !lo_q |=> !lo_q); // R7
endmodule

// File: rtl/irq_dav_flag.sv
`timescale 1ns/1ps
module irq_dav_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_done,
  input  logic timer_start,
  input  logic host_read,
  input  logic spi_mode,
  input  logic rd_release,
  output logic dav_q
);
  logic rd_pend_q;
  logic clr_any;

  assign clr_any = host_read || timer_start || rd_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
    end else if (!spi_mode || rd_release) begin
      rd_pend_q <= 1'b0;
    end else if (host_read) begin
      rd_pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dav_q <= 1'b0;
    else if (seq_done) dav_q <= 1'b1;
    else if (clr_any)  dav_q <= 1'b0;
  end

  AST_DAV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> dav_q); // R5
  AST_TIMER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start && !seq_done |=> !dav_q); // R4
  AST_SPI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend_q && !seq_done |=> !dav_q); // R6
  AST_DAV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    dav_q && !clr_any |=> dav_q); // R2
endmodule

// File: rtl/irq_pen_gate.sv
`timescale 1ns/1ps
module irq_pen_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic touch,
  input  logic pen_dis,
  input  logic conv_busy,
  output logic pen_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pen_n <= 1'b1;
    else        pen_n <= !(touch && !pen_dis && !conv_busy);
  end

  AST_PEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> pen_n); // R11
  AST_PEN_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    pen_dis |=> pen_n); // R10
  AST_PEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !touch |=> pen_n); // R10
endmodule

// File: rtl/adc_irq_ctrl.sv
`timescale 1ns/1ps
module adc_irq_ctrl #(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned NUM_CH = 3,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned ST_W  = 2 * NUM_CH
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_limit_mode,
  input  logic                    pen_dis,
  input  logic                    spi_mode,
  input  logic                    seq_done,
  input  logic                    timer_start,
  input  logic                    host_read,
  input  logic                    rd_release,
  input  logic                    conv_busy,
  input  logic                    touch,
  input  logic                    res_valid,
  input  logic [CH_W-1:0]         res_ch,
  input  logic [RES_W-1:0]        res_data,
  input  logic [NUM_CH*RES_W-1:0] lim_hi,
  input  logic [NUM_CH*RES_W-1:0] lim_lo,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [ST_W-1:0]         stat_clr,
  output logic [ST_W-1:0]         stat_q,
  output logic                    int_n,
  output logic                    pen_n
);
  import adc_irq_pkg::*;

  int_mode_e       mode;
  logic            dav_q;
  logic [ST_W-1:0] en_mask;
  logic            alarm;

  assign mode = int_mode_e'(cfg_limit_mode);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_en;
    assign wr_en          = res_valid && (res_ch == CH_W'(c));
    assign en_mask[2*c]   = ch_en[c];
    assign en_mask[2*c+1] = ch_en[c];

    irq_limit_chan #(.RES_W(RES_W)) i_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .res    (res_data),
      .lim_hi (lim_hi[c*RES_W +: RES_W]),
      .lim_lo (lim_lo[c*RES_W +: RES_W]),
      .clr_hi (stat_clr[2*c]),
      .clr_lo (stat_clr[2*c+1]),
      .hi_q   (stat_q[2*c]),
      .lo_q   (stat_q[2*c+1])
    );
  end

  irq_dav_flag i_dav (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_done    (seq_done),
    .timer_start (timer_start),
    .host_read   (host_read),
    .spi_mode    (spi_mode),
    .rd_release  (rd_release),
    .dav_q       (dav_q)
  );

  irq_pen_gate i_pen (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (touch),
    .pen_dis   (pen_dis),
    .conv_busy (conv_busy),
    .pen_n     (pen_n)
  );

  assign alarm = |(stat_q & en_mask);

  always_comb begin
    unique case (mode)
      INT_LIMIT_ALARM: int_n = !alarm;
      default:         int_n = !dav_q;
    endcase
  end

  AST_SEQ_INT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done && !cfg_limit_mode |=> !int_n || cfg_limit_mode); // R2
  AST_STAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R8
endmodule

// File: tb/test_adc_irq_ctrl.sv
`timescale 1ns/1ps
module test_adc_irq_ctrl;
  localparam int unsigned RES_W  = 12;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CH_W   = 2;
  localparam int unsigned ST_W   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_limit_mode = 1'b0, pen_dis = 1'b0, spi_mode = 1'b0;
  logic seq_done = 1'b0, timer_start = 1'b0, host_read = 1'b0, rd_release = 1'b0;
  logic conv_busy = 1'b0, touch = 1'b0, res_valid = 1'b0;
  logic [CH_W-1:0] res_ch = '0;
  logic [RES_W-1:0] res_data = '0;
  logic [NUM_CH*RES_W-1:0] lim_hi = '0, lim_lo = '0;
  logic [NUM_CH-1:0] ch_en = '0;
  logic [ST_W-1:0] stat_clr = '0;
  logic [ST_W-1:0] stat_q;
  logic int_n, pen_n;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  adc_irq_ctrl #(.RES_W(RES_W), .NUM_CH(NUM_CH)) i_adc_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_limit_mode(cfg_limit_mode), .pen_dis(pen_dis),
    .spi_mode(spi_mode), .seq_done(seq_done), .timer_start(timer_start),
    .host_read(host_read), .rd_release(rd_release), .conv_busy(conv_busy),
    .touch(touch), .res_valid(res_valid), .res_ch(res_ch), .res_data(res_data),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .ch_en(ch_en), .stat_clr(stat_clr),
    .stat_q(stat_q), .int_n(int_n), .pen_n(pen_n)
  );

  // vector: ch[39:38] data[37:26] hi[25:14] lo[13:2] exp_hi[1] exp_lo[0]
  localparam int NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 12'd3001, 12'd3000, 12'd1000, 1'b1, 1'b0},
    {2'd0, 12'd3000, 12'd3000, 12'd1000, 1'b0, 1'b0},
    {2'd1, 12'd999,  12'd3000, 12'd1000, 1'b0, 1'b1},
    {2'd1, 12'd1000, 12'd3000, 12'd1000, 1'b0, 1'b0},
    {2'd2, 12'd4095, 12'd4095, 12'd0,    1'b0, 1'b0},
    {2'd2, 12'd0,    12'd4095, 12'd0,    1'b0, 1'b0},
    {2'd2, 12'd0,    12'd4095, 12'd1,    1'b0, 1'b1},
    {2'd0, 12'd2000, 12'd3000, 12'd1000, 1'b0, 1'b0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_limits(input logic [RES_W-1:0] hi, input logic [RES_W-1:0] lo);
    for (int c = 0; c < NUM_CH; c++) begin
      lim_hi[c*RES_W +: RES_W] = hi;
      lim_lo[c*RES_W +: RES_W] = lo;
    end
  endtask

  task automatic clear_all();
    stat_clr = '1; step(); stat_clr = '0;
  endtask

  task automatic beat(input logic [CH_W-1:0] ch, input logic [RES_W-1:0] d);
    res_valid = 1'b1; res_ch = ch; res_data = d;
    step();
    res_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    // R1 during and right after reset
    touch = 1'b1;
    step(); step();
    chk("R1 int_n in reset", int_n, 1);
    chk("R1 pen_n in reset", pen_n, 1);
    chk("R1 stat in reset", stat_q, 0);
    touch = 1'b0;
    rst_n = 1'b1;
    step();
    chk("R1 int_n after reset", int_n, 1);

    // table walk: R7 comparisons and R9 alarm on int_n
    cfg_limit_mode = 1'b1; ch_en = '1;
    for (int i = 0; i < NV; i++) begin
      logic [ST_W-1:0] e;
      clear_all();
      set_limits(VEC[i][25:14], VEC[i][13:2]);
      beat(VEC[i][39:38], VEC[i][37:26]);
      e = '0;
      e[2*VEC[i][39:38]]   = VEC[i][1];
      e[2*VEC[i][39:38]+1] = VEC[i][0];
      chk("R7 status bits", stat_q, e);
      chk("R9 alarm level", int_n, !(VEC[i][1] | VEC[i][0]));
    end

    // R7 no compare without res_valid
    clear_all(); set_limits(12'd100, 12'd50);
    res_data = 12'd4000; res_ch = 2'd0; step();
    chk("R7 ignored without valid", stat_q, 0);

    // R8 sticky, W1C, set beats clear
    beat(2'd1, 12'd200);
    step(); step(); step();
    chk("R8 sticky", stat_q, 6'b000100);
    stat_clr = 6'b000100; step(); stat_clr = '0;
    chk("R8 cleared next cycle", stat_q, 0);
    res_valid = 1'b1; res_ch = 2'd1; res_data = 12'd200; stat_clr = 6'b000100;
    step();
    res_valid = 1'b0; stat_clr = '0;
    chk("R8 set wins over clear", stat_q, 6'b000100);

    // R9 masking
    ch_en = 3'b101;
    #1;
    chk("R9 masked channel int high", int_n, 1);
    chk("R9 masked still records", stat_q, 6'b000100);
    ch_en = 3'b111;
    #1;
    chk("R9 enabled channel int low", int_n, 0);

    // R12 data-ready mode ignores status
    cfg_limit_mode = 1'b0;
    #1;
    chk("R12 mode select", int_n, 1);
    clear_all();

    // R2 / R3
    seq_done = 1'b1; step(); seq_done = 1'b0;
    chk("R2 int low after done", int_n, 0);
    step(); step(); step();
    chk("R2 int stays low", int_n, 0);
    host_read = 1'b1; step(); host_read = 1'b0;
    chk("R3 read clears", int_n, 1);

    // R4
    seq_done = 1'b1; step(); seq_done = 1'b0;
    timer_start = 1'b1; step(); timer_start = 1'b0;
    chk("R4 timer clears", int_n, 1);

    // R5
    seq_done = 1'b1; host_read = 1'b1; step(); seq_done = 1'b0; host_read = 1'b0;
    chk("R5 done beats read", int_n, 0);
    host_read = 1'b1; step(); host_read = 1'b0;
    seq_done = 1'b1; timer_start = 1'b1; step(); seq_done = 1'b0; timer_start = 1'b0;
    chk("R5 done beats timer", int_n, 0);

    // R12 flag kept while in limit mode
    host_read = 1'b1; step(); host_read = 1'b0;
    cfg_limit_mode = 1'b1;
    seq_done = 1'b1; step(); seq_done = 1'b0;
    cfg_limit_mode = 1'b0;
    #1;
    chk("R12 flag tracked in limit mode", int_n, 0);
    host_read = 1'b1; step(); host_read = 1'b0;

    // R6 SPI read latch
    spi_mode = 1'b1;
    seq_done = 1'b1; step(); seq_done = 1'b0;
    host_read = 1'b1; step(); host_read = 1'b0;
    chk("R6 read clears", int_n, 1);
    seq_done = 1'b1; step(); seq_done = 1'b0;
    chk("R6 new data one cycle", int_n, 0);
    step();
    chk("R6 latch clears flag", int_n, 1);
    rd_release = 1'b1; step(); rd_release = 1'b0;
    seq_done = 1'b1; step(); seq_done = 1'b0;
    step();
    chk("R6 after release holds", int_n, 0);
    spi_mode = 1'b0;

    // R10 / R11 pen
    touch = 1'b1; step();
    chk("R10 pen follows touch", pen_n, 0);
    conv_busy = 1'b1; step();
    chk("R11 busy suppresses pen", pen_n, 1);
    conv_busy = 1'b0; pen_dis = 1'b1; step();
    chk("R10 disabled pen high", pen_n, 1);
    pen_dis = 1'b0; touch = 1'b0; step();
    chk("R10 pen idle high", pen_n, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule